// File: doc/BRIEF.md
# Filtered Phase-Lock Indicator

This block watches the divided reference pulse and the divided feedback pulse of a synthesizer loop and tells the rest of the chip whether the loop is in phase lock. Both pulse trains are synchronised into a fast sampling clock. The block counts the fast-clock cycles between their rising edges, regardless of which edge comes first, and compares that count against two programmable windows. One window qualifies a good sample and the other disqualifies a sample.

Only one phase-detector cycle in every `DECIM` is evaluated. The indicator rises after `GOOD_NEED` evaluated samples in a row fall inside the lock window. It falls on the first evaluated sample beyond the unlock window. An evaluated sample that lies between the two windows breaks the run of good samples but leaves the indicator as it is. A leading edge with no partner edge inside `TIMEOUT` fast cycles counts as a bad sample.

An enable input forces the indicator low, and so does a power-down input. Either one also clears every counter, so a fresh qualification starts when the block is enabled again. With a 100 MHz sampling clock, a window of 1 count corresponds to 10 ns.

Top module: `lockdet_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lock_out` is low after that edge.
- R2: The phase error of one phase-detector cycle is the absolute number of fast-clock cycles between the rising edge of `ref_pulse` and the rising edge of `fb_pulse`, whichever comes first. Edges in the same cycle give an error of 0.
- R3: Counting from the last clear, only every `DECIM`-th phase error is evaluated (the `DECIM`-th, the 2·`DECIM`-th, and so on). The other measurements have no effect on `lock_out`.
- R4: `lock_out` rises once `GOOD_NEED` consecutive evaluated errors are each at most `win_lock` and none of them exceeds `win_unlock`.
- R5: A single evaluated error greater than `win_unlock` drives `lock_out` low and clears the run of good samples.
- R6: An evaluated error greater than `win_lock` but at most `win_unlock` clears the run of good samples and leaves `lock_out` unchanged.
- R7: A rising edge on one input with no rising edge on the other within `TIMEOUT` cycles is evaluated as an error beyond `win_unlock`.
- R8: While `det_en` is 0 or `pwr_dn` is 1, `lock_out` is held low, and the good-run counter, the decimation counter and the measurement are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse (asynchronous) |
| fb_pulse | input | 1 | Divided feedback pulse (asynchronous) |
| win_lock | input | CNT_W | Lock window in fast-clock counts |
| win_unlock | input | CNT_W | Unlock window in fast-clock counts |
| det_en | input | 1 | Output enable; 0 forces the output low |
| pwr_dn | input | 1 | Power-down; 1 forces the output low |
| lock_out | output | 1 | Filtered lock indication |

## Verification
The bench builds the block with `CNT_W`=5, `DECIM`=4, `GOOD_NEED`=4 and `TIMEOUT`=15. With these values one lock qualification takes only sixteen reference periods. That makes it practical to sweep every pairing of lock window 0–3 with unlock window 0–2 counts above it, driving both small offsets and pseudo-random offsets and missing edges. A directed pass places bad, in-between and missing-edge samples on evaluated and on skipped positions. It also toggles enable and power-down while the block is locked, and checks that qualification restarts from zero afterwards.

// File: rtl/lockdet_pkg.sv
// Shared types of the filtered lock indicator.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package lockdet_pkg;

    // Phase measurement states: waiting for a first edge, or timing the gap.
    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_WAIT = 1'b1
    } meas_state_e;

endpackage

// File: rtl/lockdet_edge_sync.sv
// Synchronises an asynchronous pulse into the fast clock and emits a
// one-cycle strobe on each rising edge.
// Assumes: input pulses stay high for at least one fast-clock period.
module lockdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_q;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SW-2:0], din};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/lockdet_phase_meas.sv
// Measures the distance in fast-clock cycles between a reference edge and
// a feedback edge, whichever comes first. It emits one result per pair,
// or a timeout result when the partner edge does not arrive in time.
// Assumes: TIMEOUT >= 1 and TIMEOUT fits in CNT_W bits.
module lockdet_phase_meas
    import lockdet_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TIMEOUT = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_err,
    output logic             meas_tmo
);

    localparam logic [CNT_W-1:0] TMO_L = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

    meas_state_e      state_q;
    logic [CNT_W-1:0] gap_q;
    logic             lead_ref_q;
    logic             trail_seen;

    // Partner of the edge that opened the current measurement.
    always_comb begin
        trail_seen = lead_ref_q ? fb_rise : ref_rise;
    end

    // Measurement sequencer: open on a first edge, close on the partner or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q    <= MS_IDLE;
            gap_q      <= '0;
            lead_ref_q <= 1'b0;
            meas_valid <= 1'b0;
            meas_err   <= '0;
            meas_tmo   <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            meas_tmo   <= 1'b0;
            unique case (state_q)
                MS_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        meas_valid <= 1'b1;
                        meas_err   <= '0;
                    end else if (ref_rise || fb_rise) begin
                        state_q    <= MS_WAIT;
                        gap_q      <= ONE_L;
                        lead_ref_q <= ref_rise;
                    end
                end
                MS_WAIT: begin
                    if (trail_seen) begin
                        meas_valid <= 1'b1;
                        meas_err   <= gap_q;
                        state_q    <= MS_IDLE;
                    end else if (gap_q == TMO_L) begin
                        meas_valid <= 1'b1;
                        meas_tmo   <= 1'b1;
                        meas_err   <= TMO_L;
                        state_q    <= MS_IDLE;
                    end else begin
                        gap_q <= gap_q + ONE_L;
                    end
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lockdet_decim.sv
// Passes on only every DECIM-th measurement, counted from the last clear.
// Assumes: DECIM >= 2.
module lockdet_decim #(
    parameter int CNT_W = 8,
    parameter int DECIM = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_err,
    input  logic             meas_tmo,
    output logic             eval_pulse,
    output logic [CNT_W-1:0] eval_err,
    output logic             eval_tmo
);

    localparam int            DW     = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [DW-1:0] LAST_L = DW'(DECIM - 1);

    logic [DW-1:0] seen_q;

    // Count measurements and forward the last one of each group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q     <= '0;
            eval_pulse <= 1'b0;
            eval_err   <= '0;
            eval_tmo   <= 1'b0;
        end else begin
            eval_pulse <= 1'b0;
            if (meas_valid) begin
                if (seen_q == LAST_L) begin
                    seen_q     <= '0;
                    eval_pulse <= 1'b1;
                    eval_err   <= meas_err;
                    eval_tmo   <= meas_tmo;
                end else begin
                    seen_q <= seen_q + DW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lockdet_filter.sv
// Hysteresis filter: lock after GOOD_NEED consecutive in-window samples,
// unlock on a single sample beyond the unlock window.
// Assumes: GOOD_NEED >= 1; windows are held steady while enabled.
module lockdet_filter #(
    parameter int CNT_W     = 8,
    parameter int GOOD_NEED = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             eval_pulse,
    input  logic [CNT_W-1:0] eval_err,
    input  logic             eval_tmo,
    input  logic [CNT_W-1:0] win_lock,
    input  logic [CNT_W-1:0] win_unlock,
    output logic             lock_q
);

    localparam int            GW     = $clog2(GOOD_NEED + 1);
    localparam logic [GW-1:0] GOOD_L = GW'(GOOD_NEED);

    logic [GW-1:0] run_q;
    logic          is_bad;
    logic          is_good;

    // Classify the evaluated sample against both windows.
    always_comb begin
        is_bad  = eval_tmo || (eval_err > win_unlock);
        is_good = !is_bad && (eval_err <= win_lock);
    end

    // Update the good-sample run and the lock flag on each evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (eval_pulse) begin
            if (is_bad) begin
                run_q  <= '0;
                lock_q <= 1'b0;
            end else if (is_good) begin
                if (run_q != GOOD_L) begin
                    run_q <= run_q + GW'(1);
                end
                if (run_q >= GOOD_L - GW'(1)) begin
                    lock_q <= 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/lockdet_top.sv
// Filtered lock indicator: synchronises both divided pulses, measures
// their phase error, decimates, and filters with asymmetric hysteresis.
// Assumes: pulses are asynchronous to clk and wider than one clk period;
// the reference period exceeds TIMEOUT plus the pipeline depth.
module lockdet_top #(
    parameter int CNT_W       = 8,
    parameter int DECIM       = 64,
    parameter int GOOD_NEED   = 4,
    parameter int TIMEOUT     = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [CNT_W-1:0] win_lock,
    input  logic [CNT_W-1:0] win_unlock,
    input  logic             det_en,
    input  logic             pwr_dn,
    output logic             lock_out
);

    localparam int NCH = 2;

    logic [NCH-1:0]   pulse_in;
    logic [NCH-1:0]   pulse_rise;
    logic             clr;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_err;
    logic             meas_tmo;
    logic             eval_pulse;
    logic [CNT_W-1:0] eval_err;
    logic             eval_tmo;

    assign pulse_in = {fb_pulse, ref_pulse};
    assign clr      = pwr_dn | ~det_en;

    // One synchroniser per input pulse train.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
        lockdet_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pulse_in[ch]),
            .rise  (pulse_rise[ch])
        );
    end

    lockdet_phase_meas #(
        .CNT_W   (CNT_W),
        .TIMEOUT (TIMEOUT)
    ) meas_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .ref_rise   (pulse_rise[0]),
        .fb_rise    (pulse_rise[1]),
        .meas_valid (meas_valid),
        .meas_err   (meas_err),
        .meas_tmo   (meas_tmo)
    );

    lockdet_decim #(
        .CNT_W (CNT_W),
        .DECIM (DECIM)
    ) decim_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .meas_valid (meas_valid),
        .meas_err   (meas_err),
        .meas_tmo   (meas_tmo),
        .eval_pulse (eval_pulse),
        .eval_err   (eval_err),
        .eval_tmo   (eval_tmo)
    );

    lockdet_filter #(
        .CNT_W     (CNT_W),
        .GOOD_NEED (GOOD_NEED)
    ) filt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .eval_pulse (eval_pulse),
        .eval_err   (eval_err),
        .eval_tmo   (eval_tmo),
        .win_lock   (win_lock),
        .win_unlock (win_unlock),
        .lock_q     (lock_out)
    );

endmodule

// File: rtl/lockdet_chk.sv
// Property checker for lockdet_top, attached with bind below.
module lockdet_chk #(
    parameter int CNT_W   = 8,
    parameter int TIMEOUT = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_en,
    input logic             pwr_dn,
    input logic [CNT_W-1:0] win_lock,
    input logic [CNT_W-1:0] win_unlock,
    input logic             lock_out,
    input logic             clr,
    input logic             meas_valid,
    input logic [CNT_W-1:0] meas_err,
    input logic             meas_tmo,
    input logic             eval_pulse,
    input logic [CNT_W-1:0] eval_err,
    input logic             eval_tmo
);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> !lock_out);

    // R2
    err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !meas_tmo) |-> (meas_err <= CNT_W'(TIMEOUT)));

    // R3
    eval_after_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_pulse |-> $past(meas_valid));

    // R4
    rise_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_out) |-> $past(eval_pulse && !eval_tmo &&
                                  eval_err <= win_lock && eval_err <= win_unlock));

    // R5
    bad_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_pulse && !clr && (eval_tmo || eval_err > win_unlock)) |=> !lock_out);

    // R6
    mid_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_pulse && !clr && !eval_tmo && eval_err > win_lock &&
         eval_err <= win_unlock) |=> (lock_out == $past(lock_out)));

    // R8
    off_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn || !det_en) |=> !lock_out);

endmodule

bind lockdet_top lockdet_chk #(
    .CNT_W   (CNT_W),
    .TIMEOUT (TIMEOUT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_en     (det_en),
    .pwr_dn     (pwr_dn),
    .win_lock   (win_lock),
    .win_unlock (win_unlock),
    .lock_out   (lock_out),
    .clr        (clr),
    .meas_valid (meas_valid),
    .meas_err   (meas_err),
    .meas_tmo   (meas_tmo),
    .eval_pulse (eval_pulse),
    .eval_err   (eval_err),
    .eval_tmo   (eval_tmo)
);

// File: tb/lockdet_top_tb.sv
`timescale 1ns/1ps
module lockdet_top_tb_top;

    localparam int CNT_W   = 5;
    localparam int DECIM   = 4;
    localparam int GOODN   = 4;
    localparam int TMO     = 15;
    localparam int PER     = 48;
    localparam int SLOT    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_pulse = 1'b0;
    logic             fb_pulse = 1'b0;
    logic [CNT_W-1:0] win_lock = '0;
    logic [CNT_W-1:0] win_unlock = '0;
    logic             det_en = 1'b0;
    logic             pwr_dn = 1'b0;
    logic             lock_out;

    int n_chk = 0;
    int n_bad = 0;
    int mcnt, good, wl, wu;
    bit exp_lock;
    bit done = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    lockdet_top #(
        .CNT_W       (CNT_W),
        .DECIM       (DECIM),
        .GOOD_NEED   (GOODN),
        .TIMEOUT     (TMO),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_pulse),
        .fb_pulse   (fb_pulse),
        .win_lock   (win_lock),
        .win_unlock (win_unlock),
        .det_en     (det_en),
        .pwr_dn     (pwr_dn),
        .lock_out   (lock_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_out=%b expected %b (wl=%0d wu=%0d) at %0t",
                     tag, act, exp, wl, wu, $time);
        end
    endtask

    task automatic model_clear();
        mcnt = 0; good = 0; exp_lock = 1'b0;
    endtask

    // Reference model of decimation and hysteresis.
    task automatic model_step(input int err, input bit tmo);
        mcnt++;
        if (mcnt % DECIM == 0) begin
            if (tmo || err > wu) begin
                good = 0; exp_lock = 1'b0;
            end else if (err <= wl) begin
                if (good < GOODN) good++;
                if (good >= GOODN) exp_lock = 1'b1;
            end else begin
                good = 0;
            end
        end
    endtask

    // One reference period: ref edge at SLOT, feedback edge at SLOT+d.
    task automatic run_period(input int d, input bit miss_fb, input bit miss_ref,
                              input string tag);
        for (int s = 0; s < PER; s++) begin
            @(negedge clk);
            ref_pulse = (s == SLOT) && !miss_ref;
            fb_pulse  = (s == SLOT + d) && !miss_fb;
        end
        if (!det_en || pwr_dn) model_clear();
        else if (!(miss_fb && miss_ref))
            model_step((d < 0) ? -d : d, miss_fb || miss_ref);
        chk(tag, lock_out, exp_lock);
    endtask

    task automatic reconfigure(input int l, input int u);
        @(negedge clk);
        pwr_dn = 1'b1;
        wl = l; wu = u;
        win_lock = CNT_W'(l); win_unlock = CNT_W'(u);
        repeat (3) @(negedge clk);
        chk("R8 power-down", lock_out, 1'b0);
        pwr_dn = 1'b0;
        model_clear();
    endtask

    task automatic good_run(input int n, input string tag);
        for (int k = 0; k < n; k++) run_period((k % 2 == 0) ? wl : -wl, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset", lock_out, 1'b0);
        rst_n = 1'b1;
        det_en = 1'b1;
        model_clear();

        // Sweep of window pairs, small offsets then pseudo-random ones.
        for (int l = 0; l <= 3; l++) begin
            for (int u = l; u <= l + 2; u++) begin
                reconfigure(l, u);
                for (int k = 0; k < 20; k++) begin
                    int mag;
                    mag = (k + l) % (l + 1);
                    run_period((k % 2 == 0) ? mag : -mag, 1'b0, 1'b0, "R2 R4 sweep");
                end
                for (int k = 0; k < 20; k++) begin
                    int d;
                    bit mf;
                    lcg = lcg * 32'd1103515245 + 32'd12345;
                    d = int'((lcg >> 16) % (2 * u + 5)) - (u + 2);
                    mf = ((lcg >> 8) % 9) == 0;
                    run_period(d, mf, 1'b0, "R2 R5 R6 R7 sweep");
                end
            end
        end

        // Directed: wl=1, wu=3.
        reconfigure(1, 3);
        good_run(15, "R4 not yet");
        good_run(1, "R4 lock");
        for (int k = 0; k < 3; k++) run_period(9, 1'b0, 1'b0, "R3 skipped bad");
        run_period(-9, 1'b0, 1'b0, "R5 evaluated bad");
        good_run(16, "R4 relock");
        good_run(3, "R6 prep");
        run_period(2, 1'b0, 1'b0, "R6 mid keeps lock");
        for (int k = 0; k < 4; k++) run_period(9, 1'b0, 1'b0, "R5 drop");
        good_run(8, "R6 run");
        for (int k = 0; k < 4; k++) run_period(-2, 1'b0, 1'b0, "R6 mid clears run");
        good_run(12, "R6 run restarted");
        good_run(4, "R4 lock after mid");
        good_run(3, "R7 prep");
        run_period(0, 1'b1, 1'b0, "R7 missing feedback");
        good_run(16, "R4 relock");
        good_run(3, "R7 prep");
        run_period(0, 1'b0, 1'b1, "R7 missing reference");
        good_run(16, "R4 relock");

        // Enable and power-down while locked.
        @(negedge clk); det_en = 1'b0;
        good_run(16, "R8 disabled held low");
        @(negedge clk); det_en = 1'b1;
        good_run(15, "R8 counters cleared");
        good_run(1, "R8 relock");
        @(negedge clk); pwr_dn = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 power-down low", lock_out, 1'b0);
        pwr_dn = 1'b0;
        model_clear();
        good_run(2, "R8 decimation cleared");
        good_run(14, "R8 relock");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule